// File: doc/BRIEF.md
# Scan Bandwidth Matching Element

This block lets a single fast scan pin pair feed several slow internal scan chains. Serial test data enters on one pin at the fast clock rate. A small shift register collects each group of `CHAINS` consecutive bits into a word. When the last bit of a group arrives, the block fires a one-cycle `chain_shift` pulse, and every internal chain advances by one cell, taking one bit of that word. The internal chains therefore shift at 1/`CHAINS` of the pin rate, and the bandwidth is the same on both sides: one pin times the fast rate equals `CHAINS` chains times the slow rate.

On the same pulse, the tail cell of every chain is captured in parallel into an output register. That register then sends the captured bits out on the scan-out pin, one per fast cycle, starting with chain 0.

The block runs on one fast clock with a shift enable. It includes a behavioural model of the `CHAINS` internal chains, each `CHAIN_DEPTH` cells long, so it can be checked standalone. When `scan_enable` is low, all scan activity freezes. When it returns high, a fresh group starts.

Top module: `scan_bw_match`

## Requirements
- R1: While `rst_n` is low at a clock edge, `scan_out` and `chain_shift` are 0 after that edge, and every chain cell and the output register hold 0.
- R2: While `scan_enable` stays high, `chain_shift` is high for exactly one cycle in every `CHAINS` cycles. It is high in the cycle that presents the last (the `CHAINS`-th) bit of a group on `scan_in`.
- R3: Within a group, the first bit received on `scan_in` enters chain 0, the second enters chain 1, and so on up to chain `CHAINS`-1.
- R4: A chain advances only at a `chain_shift` edge. A bit entered into a chain reaches that chain's tail after `CHAIN_DEPTH` advances; before that, the tail shows the reset value 0.
- R5: At each `chain_shift` edge, the tails of all chains are loaded in parallel. In the k-th cycle after that edge (k = 0 .. `CHAINS`-1), `scan_out` shows the tail of chain k.
- R6: While `scan_enable` is low, `chain_shift` is 0, and the chains, the output register and `scan_out` hold their values.
- R7: After `scan_enable` returns high, the first bit presented starts a new group. The next `chain_shift` occurs in the `CHAINS`-th shifting cycle, whatever partial group was pending before the pause.
- R8: The output register fills with 0 as it shifts. If a pause cuts a group short, any output cycle beyond the `CHAINS` loaded bits shows 0 until the next parallel load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pin-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_enable | input | 1 | High: shift mode; low: capture/hold |
| scan_in | input | 1 | Serial scan data from the pin |
| scan_out | output | 1 | Serial scan data to the pin, chain 0 first within a group |
| chain_shift | output | 1 | One-cycle pulse when the internal chains advance |

## Verification
The hardest situation to reach is a pause that falls inside a group. Here the deserializer holds a partial word, the counter restarts, and the output register has already sent only some of its bits. This is what exposes the zero fill and the group realignment. Directed sequences stop shifting at chosen group positions and hold capture for several cycles before resuming. A long random run then mixes short capture bursts at random offsets with random scan data. Throughout, a cycle-level bench model predicts every `scan_out` bit and `chain_shift` pulse.

// File: rtl/bwm_pkg.sv
// Shared definitions for the scan bandwidth matching element.
// Assumes: nothing beyond standard SystemVerilog.
package bwm_pkg;

    // Operating mode decoded from the scan enable pin.
    typedef enum logic {
        MODE_HOLD  = 1'b0,
        MODE_SHIFT = 1'b1
    } bwm_mode_e;

endpackage

// File: rtl/bwm_group_counter.sv
// Counts pin-rate cycles within a group of LANES bits and flags the last one.
// Assumes: LANES >= 2; CW wide enough to hold LANES-1.
// In hold mode the position clears, so shifting resumes at group start.
module bwm_group_counter #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CW    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_enable,
    output logic group_done
);
    import bwm_pkg::*;

    localparam logic [CW-1:0] LAST_SLOT = CW'(LANES - 1);

    bwm_mode_e       mode;
    logic [CW-1:0]   slot;

    // Decode the pin into a named mode.
    always_comb mode = bwm_mode_e'(scan_enable);

    // Advance the slot position, wrapping at the end of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (mode == MODE_HOLD) begin
            slot <= '0;
        end else if (slot == LAST_SLOT) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // Flag the cycle that carries the final bit of a group.
    always_comb group_done = (mode == MODE_SHIFT) && (slot == LAST_SLOT);

endmodule

// File: rtl/bwm_deserializer.sv
// Serial-to-parallel stage: gathers LANES pin bits into one word.
// Assumes: LANES >= 2. word[0] is the first bit of the group. The word is
// valid in the cycle the last bit is on ser_in (that bit is passed straight through).
module bwm_deserializer #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [LANES-1:0] word
);
    logic stage [LANES-1];

    for (genvar g = 0; g < LANES - 1; g++) begin : g_stage
        if (g == LANES - 2) begin : g_entry
            // Newest bit enters the top stage.
            always_ff @(posedge clk) begin
                if (!rst_n)        stage[g] <= 1'b0;
                else if (shift_en) stage[g] <= ser_in;
            end
        end else begin : g_inner
            // Older bits move one stage toward lane 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        stage[g] <= 1'b0;
                else if (shift_en) stage[g] <= stage[g+1];
            end
        end
        assign word[g] = stage[g];
    end

    assign word[LANES-1] = ser_in;

endmodule

// File: rtl/bwm_chain_bank.sv
// Behavioural model of LANES internal scan chains, DEPTH cells each.
// Assumes: DEPTH >= 2. Every chain advances together on 'advance'.
// Chain g takes word[g] at its head and exposes its last cell on tails[g].
module bwm_chain_bank #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [LANES-1:0] word,
    output logic [LANES-1:0] tails
);
    for (genvar g = 0; g < LANES; g++) begin : g_chain
        logic [DEPTH-1:0] cells;

        // Shift this chain by one cell on each slow advance.
        always_ff @(posedge clk) begin
            if (!rst_n)       cells <= '0;
            else if (advance) cells <= {cells[DEPTH-2:0], word[g]};
        end

        assign tails[g] = cells[DEPTH-1];
    end

endmodule

// File: rtl/bwm_serializer.sv
// Parallel-to-serial stage: loads LANES bits at once, emits lane 0 first.
// Assumes: load has priority over shift. Zeros fill from the top.
module bwm_serializer #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic [LANES-1:0] par_in,
    output logic             ser_out
);
    logic [LANES-1:0] hold_q;

    // Parallel capture or one-place shift toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (load)     hold_q <= par_in;
        else if (shift_en) hold_q <= {1'b0, hold_q[LANES-1:1]};
    end

    assign ser_out = hold_q[0];

endmodule

// File: rtl/scan_bw_match.sv
// Top of the scan bandwidth matching element. One fast pin pair serves
// CHAINS slow chains; the chains advance once per CHAINS pin cycles.
// Assumes: 2 <= CHAINS <= 8, CHAIN_DEPTH >= 2, a single clock, synchronous reset.
module scan_bw_match #(
    parameter int unsigned CHAINS      = 4,
    parameter int unsigned CHAIN_DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_enable,
    input  logic scan_in,
    output logic scan_out,
    output logic chain_shift
);
    localparam int unsigned CNT_W = (CHAINS <= 2) ? 1 : $clog2(CHAINS);

    logic [CHAINS-1:0] in_word;
    logic [CHAINS-1:0] chain_tails;

    bwm_group_counter #(.LANES(CHAINS), .CW(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_enable (scan_enable),
        .group_done  (chain_shift)
    );

    bwm_deserializer #(.LANES(CHAINS)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (scan_enable),
        .ser_in   (scan_in),
        .word     (in_word)
    );

    bwm_chain_bank #(.LANES(CHAINS), .DEPTH(CHAIN_DEPTH)) u_chains (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (chain_shift),
        .word    (in_word),
        .tails   (chain_tails)
    );

    bwm_serializer #(.LANES(CHAINS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (chain_shift),
        .shift_en (scan_enable),
        .par_in   (chain_tails),
        .ser_out  (scan_out)
    );

endmodule

// File: rtl/scan_bw_match_chk.sv
// Property checker for scan_bw_match, attached by bind below.
// Assumes: LANES <= 255 so the gap counter fits in 8 bits.
module scan_bw_match_chk #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_enable,
    input logic             scan_out,
    input logic             chain_shift,
    input logic [LANES-1:0] chain_tails
);
    logic [7:0] gap_q;

    // Count shifting cycles since the last pulse or pause.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_enable || chain_shift) gap_q <= 8'd0;
        else                                       gap_q <= gap_q + 8'd1;
    end

    // R2
    pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_shift |-> gap_q == 8'(LANES - 1));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_shift |=> !chain_shift);

    // R6
    hold_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_enable |-> !chain_shift);

    // R6
    hold_out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_enable |=> $stable(scan_out));

    // R4
    chains_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_shift |=> $stable(chain_tails));

    // R5
    first_lane_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_shift |=> scan_out == $past(chain_tails[0]));

endmodule

bind scan_bw_match scan_bw_match_chk #(.LANES(CHAINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_enable (scan_enable),
    .scan_out    (scan_out),
    .chain_shift (chain_shift),
    .chain_tails (chain_tails)
);

// File: tb/scan_bw_match_tb.sv
module scan_bw_match_tb;
    localparam int N = 4;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_enable = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic chain_shift;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic [D-1:0] m_chain [N];
    logic [N-1:0] m_buf;
    logic [N-1:0] m_word;
    int           m_cnt;
    int           m_pos;

    always #10 clk = ~clk;

    scan_bw_match #(.CHAINS(N), .CHAIN_DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable),
        .scan_in(scan_in), .scan_out(scan_out), .chain_shift(chain_shift)
    );

    function automatic logic exp_shift(input logic se);
        return se && (m_cnt == N - 1);
    endfunction

    function automatic logic exp_out();
        return (m_pos < N) ? m_buf[m_pos] : 1'b0;
    endfunction

    function automatic logic pat_bit(input int lane, input int grp);
        return ((lane + 1) * (grp + 3) + lane) % 3 == 0;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_chain[i] = '0;
        m_buf = '0; m_word = '0; m_cnt = 0; m_pos = 0;
    endtask

    task automatic model_update(input logic se, input logic si);
        if (se) begin
            m_word[m_cnt] = si;
            if (m_cnt == N - 1) begin
                for (int i = 0; i < N; i++) m_buf[i] = m_chain[i][D-1];
                for (int i = 0; i < N; i++) m_chain[i] = {m_chain[i][D-2:0], m_word[i]};
                m_pos = 0;
                m_cnt = 0;
            end else begin
                m_cnt++;
                m_pos++;
            end
        end else begin
            m_cnt = 0;
        end
    endtask

    task automatic step(input logic se, input logic si, input string tag_so, input string tag_cs);
        @(negedge clk);
        scan_enable = se;
        scan_in = si;
        #5;
        check(chain_shift, exp_shift(se), se ? tag_cs : "R6");
        check(scan_out, exp_out(), tag_so);
        @(posedge clk);
        #1 model_update(se, si);
    endtask

    initial begin
        void'($urandom(32'h0005_eed1));
        model_reset();
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(scan_out, 1'b0, "R1");
        check(chain_shift, 1'b0, "R1");
        rst_n = 1'b1;

        // R4: first D groups return the reset contents of the chains
        for (int g = 0; g < D; g++)
            for (int k = 0; k < N; k++) step(1'b1, pat_bit(k, g), "R4", "R2");
        // R3: unload shows each lane in chain order
        for (int g = 0; g < D + 1; g++)
            for (int k = 0; k < N; k++) step(1'b1, 1'b0, "R3", "R2");

        // R3: directed check on lane ordering with a single marker bit per group
        for (int g = 0; g < 2 * D + 1; g++)
            for (int k = 0; k < N; k++) step(1'b1, (k == (g % N)), "R3", "R2");

        // R6 / R7: pause after two bits of a group, then resume
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, "R5", "R2");
        for (int c = 0; c < 5; c++) step(1'b0, 1'($urandom), "R6", "R6");
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < N; k++) step(1'b1, 1'($urandom), "R7", "R7");

        // R8: pause after a group boundary plus two output bits, then zero fill
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, "R8", "R2");
        for (int c = 0; c < 3; c++) step(1'b0, 1'b1, "R6", "R6");
        for (int k = 0; k < N; k++) step(1'b1, 1'b1, "R8", "R7");

        // R5: random data with short random pauses
        for (int c = 0; c < 3000; c++) begin
            logic se;
            se = ($urandom % 10) != 0;
            step(se, 1'($urandom), "R5", "R2");
        end

        // R3: final unload of all chains
        for (int g = 0; g < D + 1; g++)
            for (int k = 0; k < N; k++) step(1'b1, 1'b0, "R3", "R2");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule